// File: doc/BRIEF.md
# Segment Lookaside Table

This block holds a small, fully associative set of segment descriptors for a 64-bit address space with 256 MB segments. Each slot keeps two 64-bit words. The tag word holds an effective segment number in bits 63:28 and a valid flag at bit 27. The descriptor word is stored exactly as software supplied it. A translation probe takes an effective address and a privilege bit. In the same cycle it returns hit or miss, the matching slot, the virtual segment number, the low attribute field, a page-size shift, a protection key chosen by privilege, and a no-execute flag.

Software fills a slot with a single write command. The slot number travels in the low twelve bits of the tag operand. Entries are removed in one of two ways: by effective address, or all at once. The bulk form always spares slot 0. Whenever a removal actually drops a live entry, the block emits a one-cycle request to flush the downstream translation cache. A write aimed past the last implemented slot is refused and reported. All updates are registered, and the probe is combinational against the stored entries.

Top module: `seg_xlate_table`

## Requirements
- R1: A write takes its slot number from bits 11:0 of `wr_esid_word`. It stores that operand with bits 11:0 cleared as the slot's tag word, and stores `wr_vsid_word` unchanged as the slot's descriptor word. The new contents are visible to probes from the cycle after the write edge.
- R2: A write whose slot number is at least `NUM_SLOTS` changes no slot. It raises `wr_err` for exactly the one cycle after the edge that sampled it. Otherwise `wr_err` is 0.
- R3: A probe hits only a slot whose whole tag word equals `{lk_addr[63:28], 1'b1, 27'b0}`. A slot with bit 27 clear, or with any of bits 26:12 set, never hits.
- R4: When several slots hit, `lk_slot` reports the lowest-numbered one.
- R5: On a hit, `lk_vsid` is bits 61:12 of the hit slot's descriptor word, and `lk_attr` is bits 11:0 of that word.
- R6: On a hit, `lk_pg_shift` is 24 when descriptor bit 8 is set and 12 when it is clear.
- R7: On a hit, `lk_key` is descriptor bit 10 when `lk_problem` is 1 and descriptor bit 11 when `lk_problem` is 0. `lk_noexec` is descriptor bit 9.
- R8: On a miss, `lk_hit`, `lk_slot`, `lk_vsid`, `lk_attr`, `lk_pg_shift`, `lk_key` and `lk_noexec` are all zero.
- R9: `inva_en` clears the valid bit of every slot except slot 0. `flush_req` pulses in the next cycle if any slot it cleared had been valid.
- R10: `inv1_en` probes `inv1_addr` with the R3/R4 rule. On a hit it clears that slot's valid bit and pulses `flush_req` in the next cycle. On a miss it changes nothing.
- R11: When a write and an invalidate land in the same cycle, the write is applied after the invalidate, so the written slot keeps what was written.
- R12: Synchronous reset leaves every slot invalid, with `flush_req` and `wr_err` at 0.
- R13: `flush_req` is a single-cycle pulse, and it is 0 in any cycle whose previous edge cleared no live slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write command strobe |
| wr_esid_word | input | 64 | Tag operand; bits 11:0 select the slot |
| wr_vsid_word | input | 64 | Descriptor operand, stored as given |
| wr_err | output | 1 | Out-of-range slot pulse |
| lk_addr | input | 64 | Probe effective address |
| lk_problem | input | 1 | 1 for problem (user) state, 0 for supervisor |
| lk_hit | output | 1 | Probe hit |
| lk_slot | output | clog2(NUM_SLOTS) | Hit slot number |
| lk_vsid | output | 50 | Virtual segment number |
| lk_attr | output | 12 | Attribute field |
| lk_pg_shift | output | 5 | Page offset width, 12 or 24 |
| lk_key | output | 1 | Privilege-selected protection key |
| lk_noexec | output | 1 | No-execute flag |
| inv1_en | input | 1 | Invalidate-by-address strobe |
| inv1_addr | input | 64 | Address for invalidate-by-address |
| inva_en | input | 1 | Invalidate-all strobe |
| flush_req | output | 1 | Translation cache flush request pulse |

## Verification
Three collisions can occur within one edge, and the bench provokes each deliberately: a write meets a bulk invalidate, a write meets an invalidate-by-address aimed at the same slot, and a bulk invalidate meets an invalidate-by-address. In every case the bench drives all strobes together for a single cycle. A reference model applies the invalidations first and the write last, and from that model the bench predicts the surviving contents. The outcome is then judged at the ports: probes of every slot after the edge, and the flush and error pulses one cycle later.

// File: rtl/segtab_pkg.sv
package segtab_pkg;

    localparam int WORD_W      = 64;
    localparam int SLOT_FIELD  = 12;
    localparam int SEG_SHIFT   = 28;
    localparam int VALID_BIT   = 27;
    localparam int VSID_LSB    = 12;
    localparam int VSID_MSB    = 61;
    localparam int VSID_W      = VSID_MSB - VSID_LSB + 1;
    localparam int ATTR_W      = 12;
    localparam int LARGE_BIT   = 8;
    localparam int NOEXEC_BIT  = 9;
    localparam int KEYP_BIT    = 10;
    localparam int KEYS_BIT    = 11;
    localparam int SHIFT_W     = 5;
    localparam logic [SHIFT_W-1:0] SHIFT_SMALL = 5'd12;
    localparam logic [SHIFT_W-1:0] SHIFT_LARGE = 5'd24;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [VSID_W-1:0]  vsid;
        logic [ATTR_W-1:0]  attr;
        logic [SHIFT_W-1:0] pg_shift;
        logic               key;
        logic               noexec;
    } xlate_t;

    // Compare key for a probe: segment number, valid flag set, rest zero.
    function automatic word_t seg_key(input word_t ea);
        word_t k;
        k = '0;
        k[WORD_W-1:SEG_SHIFT] = ea[WORD_W-1:SEG_SHIFT];
        k[VALID_BIT] = 1'b1;
        return k;
    endfunction

    function automatic xlate_t unpack_desc(input word_t dw, input logic problem);
        xlate_t x;
        x.vsid     = dw[VSID_MSB:VSID_LSB];
        x.attr     = dw[ATTR_W-1:0];
        x.pg_shift = dw[LARGE_BIT] ? SHIFT_LARGE : SHIFT_SMALL;
        x.key      = problem ? dw[KEYP_BIT] : dw[KEYS_BIT];
        x.noexec   = dw[NOEXEC_BIT];
        return x;
    endfunction

endpackage

// File: rtl/segtab_store.sv
module segtab_store
    import segtab_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    parameter int SLOT_W    = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  word_t             wr_esid_word,
    input  word_t             wr_vsid_word,
    input  logic              inv1_en,
    input  logic              inv1_hit,
    input  logic [SLOT_W-1:0] inv1_slot,
    input  logic              inva_en,
    output word_t             esid_tab [NUM_SLOTS],
    output word_t             vsid_tab [NUM_SLOTS],
    output logic              flush_req,
    output logic              wr_err
);

    word_t esid_q [NUM_SLOTS];
    word_t vsid_q [NUM_SLOTS];

    logic [SLOT_FIELD-1:0] wr_slot;
    logic                  slot_ok;
    logic                  bulk_live;
    logic                  single_fire;

    assign wr_slot     = wr_esid_word[SLOT_FIELD-1:0];
    assign slot_ok     = 32'(wr_slot) < NUM_SLOTS;
    assign single_fire = inv1_en && inv1_hit;

    always_comb begin
        bulk_live = 1'b0;
        for (int i = 1; i < NUM_SLOTS; i++) begin
            bulk_live = bulk_live | esid_q[i][VALID_BIT];
        end
    end

    // Invalidates first, write last: the later nonblocking update wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                esid_q[i] <= '0;
                vsid_q[i] <= '0;
            end
            flush_req <= 1'b0;
            wr_err    <= 1'b0;
        end else begin
            flush_req <= single_fire || (inva_en && bulk_live);
            wr_err    <= wr_en && !slot_ok;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (inva_en && i != 0) begin
                    esid_q[i][VALID_BIT] <= 1'b0;
                end
                if (single_fire && inv1_slot == SLOT_W'(i)) begin
                    esid_q[i][VALID_BIT] <= 1'b0;
                end
                if (wr_en && slot_ok && wr_slot == SLOT_FIELD'(i)) begin
                    esid_q[i] <= {wr_esid_word[WORD_W-1:SLOT_FIELD], {SLOT_FIELD{1'b0}}};
                    vsid_q[i] <= wr_vsid_word;
                end
            end
        end
    end

    assign esid_tab = esid_q;
    assign vsid_tab = vsid_q;

    a_r2_bad_write_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !slot_ok) |=> wr_err);

    a_r9_slot0_kept: assert property (@(posedge clk) disable iff (rst)
        (inva_en && !(single_fire && inv1_slot == '0) && !(wr_en && wr_slot == '0))
        |=> $stable(esid_q[0][VALID_BIT]));

    a_r13_flush_single: assert property (@(posedge clk) disable iff (rst)
        (!inv1_en && !inva_en) |=> !flush_req);

endmodule

// File: rtl/segtab_match.sv
module segtab_match
    import segtab_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    parameter int SLOT_W    = 6
) (
    input  word_t             tab [NUM_SLOTS],
    input  word_t             key,
    output logic              hit,
    output logic [SLOT_W-1:0] slot
);

    // Scan downward so the lowest matching slot is the last one assigned.
    always_comb begin
        hit  = 1'b0;
        slot = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (tab[i] == key) begin
                hit  = 1'b1;
                slot = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/segtab_decode.sv
module segtab_decode
    import segtab_pkg::*;
(
    input  logic   hit,
    input  word_t  desc,
    input  logic   problem,
    output xlate_t xl
);

    always_comb begin
        xl = '0;
        if (hit) begin
            xl = unpack_desc(desc, problem);
        end
    end

endmodule

// File: rtl/seg_xlate_table.sv
module seg_xlate_table
    import segtab_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [63:0]         wr_esid_word,
    input  logic [63:0]         wr_vsid_word,
    output logic                wr_err,
    input  logic [63:0]         lk_addr,
    input  logic                lk_problem,
    output logic                lk_hit,
    output logic [SLOT_W-1:0]   lk_slot,
    output logic [49:0]         lk_vsid,
    output logic [11:0]         lk_attr,
    output logic [4:0]          lk_pg_shift,
    output logic                lk_key,
    output logic                lk_noexec,
    input  logic                inv1_en,
    input  logic [63:0]         inv1_addr,
    input  logic                inva_en,
    output logic                flush_req
);

    localparam int N_PROBES = 2;   // 0: translation, 1: invalidate-by-address

    word_t             esid_tab [NUM_SLOTS];
    word_t             vsid_tab [NUM_SLOTS];
    word_t             probe_key  [N_PROBES];
    logic              probe_hit  [N_PROBES];
    logic [SLOT_W-1:0] probe_slot [N_PROBES];
    xlate_t            xl;

    assign probe_key[0] = seg_key(lk_addr);
    assign probe_key[1] = seg_key(inv1_addr);

    for (genvar g = 0; g < N_PROBES; g++) begin : g_probe
        segtab_match #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_match (
            .tab  (esid_tab),
            .key  (probe_key[g]),
            .hit  (probe_hit[g]),
            .slot (probe_slot[g])
        );
    end

    segtab_store #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_store (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_esid_word (wr_esid_word),
        .wr_vsid_word (wr_vsid_word),
        .inv1_en      (inv1_en),
        .inv1_hit     (probe_hit[1]),
        .inv1_slot    (probe_slot[1]),
        .inva_en      (inva_en),
        .esid_tab     (esid_tab),
        .vsid_tab     (vsid_tab),
        .flush_req    (flush_req),
        .wr_err       (wr_err)
    );

    segtab_decode u_decode (
        .hit     (probe_hit[0]),
        .desc    (vsid_tab[probe_slot[0]]),
        .problem (lk_problem),
        .xl      (xl)
    );

    assign lk_hit      = probe_hit[0];
    assign lk_slot     = probe_slot[0];
    assign lk_vsid     = xl.vsid;
    assign lk_attr     = xl.attr;
    assign lk_pg_shift = xl.pg_shift;
    assign lk_key      = xl.key;
    assign lk_noexec   = xl.noexec;

    a_r3_hit_entry_matches: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (esid_tab[lk_slot] == seg_key(lk_addr)));

    a_r8_miss_outputs_zero: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_vsid == '0 && lk_attr == '0 && lk_pg_shift == '0
                     && !lk_key && !lk_noexec && lk_slot == '0));

    a_r7_key_select: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_problem) |-> (lk_key == vsid_tab[lk_slot][KEYP_BIT]));

    a_r10_inv_hit_flush: assert property (@(posedge clk) disable iff (rst)
        (inv1_en && probe_hit[1]) |=> flush_req);

endmodule

// File: tb/sim_seg_xlate_table.sv
module sim_seg_xlate_table;

    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_esid_word = '0;
    logic [63:0] wr_vsid_word = '0;
    logic        wr_err;
    logic [63:0] lk_addr = '0;
    logic        lk_problem = 1'b0;
    logic        lk_hit;
    logic [2:0]  lk_slot;
    logic [49:0] lk_vsid;
    logic [11:0] lk_attr;
    logic [4:0]  lk_pg_shift;
    logic        lk_key;
    logic        lk_noexec;
    logic        inv1_en = 1'b0;
    logic [63:0] inv1_addr = '0;
    logic        inva_en = 1'b0;
    logic        flush_req;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_esid [NS];
    logic [63:0] m_vsid [NS];

    always #2 clk = ~clk;

    seg_xlate_table #(.NUM_SLOTS(NS)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_esid_word(wr_esid_word),
        .wr_vsid_word(wr_vsid_word), .wr_err(wr_err), .lk_addr(lk_addr),
        .lk_problem(lk_problem), .lk_hit(lk_hit), .lk_slot(lk_slot),
        .lk_vsid(lk_vsid), .lk_attr(lk_attr), .lk_pg_shift(lk_pg_shift),
        .lk_key(lk_key), .lk_noexec(lk_noexec), .inv1_en(inv1_en),
        .inv1_addr(inv1_addr), .inva_en(inva_en), .flush_req(flush_req)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int model_find(input logic [63:0] a);
        int e = -1;
        for (int i = 0; i < NS; i++)
            if (e < 0 && m_esid[i] == {a[63:28], 1'b1, 27'b0}) e = i;
        return e;
    endfunction

    function automatic logic [63:0] seg_of(input int i);
        return {36'hA_0000_0000 + 36'(i * 7 + 3), 28'h0};
    endfunction

    task automatic look(input logic [63:0] a);
        int e;
        logic [63:0] vw;
        e = model_find(a);
        lk_addr = a;
        for (int p = 0; p < 2; p++) begin
            lk_problem = p[0];
            #1;
            if (e < 0) begin
                chk(!lk_hit, "R8 miss flag", 64'(lk_hit), 0);
                chk(lk_vsid == 0 && lk_attr == 0 && lk_pg_shift == 0 && !lk_key && !lk_noexec && lk_slot == 0,
                    "R8 outputs zero on miss", {lk_vsid, lk_attr, 2'b0}, 0);
            end else begin
                vw = m_vsid[e];
                chk(lk_hit && lk_slot == 3'(e), "R3/R4 hit slot", {60'(lk_hit), 1'b0, lk_slot}, 64'(e));
                chk(lk_vsid == vw[61:12], "R5 vsid field", 64'(lk_vsid), 64'(vw[61:12]));
                chk(lk_attr == vw[11:0], "R5 attr field", 64'(lk_attr), 64'(vw[11:0]));
                chk(lk_pg_shift == (vw[8] ? 5'd24 : 5'd12), "R6 page shift", 64'(lk_pg_shift), vw[8] ? 24 : 12);
                chk(lk_key == (p[0] ? vw[10] : vw[11]), "R7 key select", 64'(lk_key), 64'(p[0] ? vw[10] : vw[11]));
                chk(lk_noexec == vw[9], "R7 noexec", 64'(lk_noexec), 64'(vw[9]));
            end
        end
    endtask

    task automatic look_all();
        for (int i = 0; i < NS; i++) look(seg_of(i) | 64'(28'h5A5_A5A5 + i));
    endtask

    // Model: invalidations first, then the write (R11).
    task automatic step(input bit we, input logic [63:0] ew, input logic [63:0] vw,
                        input bit i1, input logic [63:0] ia, input bit iall, input string tag);
        int h = -1;
        bit ef = 1'b0;
        bit ee;
        if (i1) h = model_find(ia);
        if (h >= 0) ef = 1'b1;
        if (iall) for (int i = 1; i < NS; i++) if (m_esid[i][27]) ef = 1'b1;
        if (h >= 0) m_esid[h][27] = 1'b0;
        if (iall) for (int i = 1; i < NS; i++) m_esid[i][27] = 1'b0;
        ee = we && (int'(ew[11:0]) >= NS);
        if (we && !ee) begin
            m_esid[ew[2:0]] = {ew[63:12], 12'h000};
            m_vsid[ew[2:0]] = vw;
        end
        wr_en = we; wr_esid_word = ew; wr_vsid_word = vw;
        inv1_en = i1; inv1_addr = ia; inva_en = iall;
        tick();
        wr_en = 1'b0; inv1_en = 1'b0; inva_en = 1'b0;
        chk(flush_req == ef, {tag, " R9/R10 flush"}, 64'(flush_req), 64'(ef));
        chk(wr_err == ee, {tag, " R2 error"}, 64'(wr_err), 64'(ee));
        tick();
        chk(!flush_req && !wr_err, {tag, " R13 single pulse"}, {62'b0, flush_req, wr_err}, 0);
    endtask

    function automatic logic [63:0] esid_op(input int seg_i, input int slot);
        return seg_of(seg_i) | 64'h0800_0000 | 64'(slot);
    endfunction

    function automatic logic [63:0] vsid_op(input int i);
        return (64'hC123_4567_89AB_C000 * 64'(i + 1)) ^ 64'(12'h0F0 + 12'(i * 12'h123));
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        for (int i = 0; i < NS; i++) m_esid[i][27] = 1'b0;
        chk(!flush_req && !wr_err, "R12 reset pulses low", {62'b0, flush_req, wr_err}, 0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin m_esid[i] = '0; m_vsid[i] = '0; end
        do_reset();
        // R12: everything misses after reset
        look_all();
        look(64'h0);

        // R1: fill each slot, then probe the whole table after every write
        for (int i = 0; i < NS; i++) begin
            step(1'b1, esid_op(i, i), vsid_op(i), 1'b0, 0, 1'b0, "R1 fill");
            look_all();
        end

        // R2: out-of-range slot numbers are refused
        step(1'b1, esid_op(20, NS), vsid_op(20), 1'b0, 0, 1'b0, "R2 slot=N");
        step(1'b1, esid_op(21, 4095), vsid_op(21), 1'b0, 0, 1'b0, "R2 slot=4095");
        step(1'b1, esid_op(22, 100), vsid_op(22), 1'b0, 0, 1'b0, "R2 slot=100");
        look_all();
        look(seg_of(20)); look(seg_of(21));

        // R3: valid flag clear, or stray bits 26:12 set, never match
        step(1'b1, seg_of(30) | 64'(6), vsid_op(30), 1'b0, 0, 1'b0, "R3 no valid");
        look(seg_of(30));
        step(1'b1, seg_of(31) | 64'h0800_0000 | 64'h0000_1000 | 64'(6), vsid_op(31), 1'b0, 0, 1'b0, "R3 stray bits");
        look(seg_of(31));

        // R4: duplicate segment in slots 2 and 5
        step(1'b1, esid_op(2, 5), vsid_op(9), 1'b0, 0, 1'b0, "R4 duplicate");
        look(seg_of(2));

        // R10: invalidate-by-address hit clears slot 2, slot 5 then wins
        step(1'b0, 0, 0, 1'b1, seg_of(2) | 64'h123, 1'b0, "R10 inv hit");
        look(seg_of(2));
        step(1'b0, 0, 0, 1'b1, seg_of(40), 1'b0, "R10 inv miss");
        look_all();

        // R9: bulk invalidate keeps slot 0
        step(1'b0, 0, 0, 1'b0, 0, 1'b1, "R9 bulk");
        look_all();
        step(1'b0, 0, 0, 1'b0, 0, 1'b1, "R9 bulk nothing live");
        look_all();

        // R11: write meets bulk invalidate
        step(1'b1, esid_op(3, 3), vsid_op(3), 1'b0, 0, 1'b1, "R11 write+bulk");
        look_all();
        // R11: write meets invalidate-by-address on the same slot
        step(1'b1, esid_op(11, 3), vsid_op(11), 1'b1, seg_of(3), 1'b0, "R11 write+inv same slot");
        look_all(); look(seg_of(11));
        // bulk and by-address in one cycle, hitting slot 0 by address
        step(1'b1, esid_op(12, 6), vsid_op(12), 1'b1, seg_of(0), 1'b1, "R11 all three");
        look_all(); look(seg_of(12));
        // by-address removal of slot 0 is allowed
        look(seg_of(0));

        // Full refill with large-page and key variations, then reset
        for (int i = 0; i < NS; i++) begin
            step(1'b1, esid_op(i + 50, i), vsid_op(i + 50) ^ 64'(i << 8), 1'b0, 0, 1'b0, "R1 refill");
        end
        for (int i = 0; i < NS; i++) look(seg_of(i + 50));
        do_reset();
        for (int i = 0; i < NS; i++) look(seg_of(i + 50));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule